// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block owns the program counter of a 32-bit RISC core and works out where the next instruction comes from. Each cycle the decoder presents an instruction class together with the fields it needs: a 16-bit branch offset, a 26-bit jump target, the two source register values and a destination register index. When `step` is high, the unit loads the selected next address into its PC register on the rising clock edge. When `step` is low, the PC is held.

Conditional branches compare two registers for equality or inequality, or test one register's sign and zero state. A taken branch goes to PC+4 plus the sign-extended word offset. Direct jumps stay inside the 256 MB region of the incremented PC. Register jumps load the PC from a source value. The link value for the two linking jumps is presented in the same cycle, as a write request to the register file. A write aimed at register 0 is never requested.

An exception redirect overrides every other selection and cancels the link write.

Top module: `npc_unit`

## Requirements
- R1: Class code 0 (sequential) and the unused codes 11 to 15 load PC+4.
- R2: A taken branch loads PC+4 + (sign-extended offset << 2). A branch that is not taken loads PC+4.
- R3: Code 1 branches when rs equals rt. Code 2 branches when rs differs from rt.
- R4: Codes 3, 4, 5 and 6 treat rs as a signed value and branch on rs >= 0, rs > 0, rs <= 0 and rs < 0 respectively.
- R5: Codes 7 (jump) and 8 (jump and link) load {PC+4 bits 31:28, target, 2'b00}. The region bits come from PC+4, not from PC.
- R6: Codes 9 (register jump) and 10 (register jump and link) load rs unchanged.
- R7: In the cycle that code 8 is presented, the unit requests a write of PC+4 to register 31. In the cycle that code 10 is presented, it requests a write of PC+4 to register rd. No other code requests a write.
- R8: A link write to register 0 is never requested.
- R9: When `exc_req` is high, the unit loads `exc_pc` whatever the class, and requests no link write.
- R10: While `step` is low, the PC holds its value.
- R11: Reset loads RESET_PC (default 0xBFC00000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| step | input | 1 | advance the PC this cycle |
| op | input | 4 | instruction class code |
| br_off | input | 16 | branch word offset |
| jmp_tgt | input | 26 | direct jump target field |
| rs_val | input | 32 | first source register value |
| rt_val | input | 32 | second source register value |
| rd_idx | input | 5 | destination index for register jump and link |
| exc_req | input | 1 | exception redirect request |
| exc_pc | input | 32 | exception redirect address |
| pc | output | 32 | current program counter |
| link_we | output | 1 | link write request |
| link_idx | output | 5 | link destination register |
| link_data | output | 32 | link value (PC+4) |

## Verification
The link outputs are combinational. They are due in the same cycle as the class code, so the bench samples them one time step after it drives the inputs on the falling edge. The new PC is due one rising edge after `step`, so the bench waits through that edge and compares `pc` at the next falling edge. Each vector first places the PC at a chosen start address through the exception redirect, which costs one extra edge. The bench then applies the instruction under test.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [3:0] {
      OP_SEQ  = 4'd0,
      OP_BEQ  = 4'd1,
      OP_BNE  = 4'd2,
      OP_BGEZ = 4'd3,
      OP_BGTZ = 4'd4,
      OP_BLEZ = 4'd5,
      OP_BLTZ = 4'd6,
      OP_J    = 4'd7,
      OP_JAL  = 4'd8,
      OP_JR   = 4'd9,
      OP_JALR = 4'd10
   } npc_op_e;

   function automatic logic is_branch(npc_op_e o);
      return (o >= OP_BEQ) && (o <= OP_BLTZ);
   endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  npc_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            taken
);
   logic neg, zero, same;
   assign neg  = a[XLEN-1];
   assign zero = (a == '0);
   assign same = (a == b);

   always_comb begin
      unique case (op)
         OP_BEQ:  taken = same;
         OP_BNE:  taken = !same;
         OP_BGEZ: taken = !neg;
         OP_BGTZ: taken = !neg && !zero;
         OP_BLEZ: taken = neg || zero;
         OP_BLTZ: taken = neg;
         default: taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN            = 32,
   parameter int OFF_W           = 16,
   parameter int TGT_W           = 26,
   parameter bit REGION_FROM_INC = 1'b1
) (
   input  logic [XLEN-1:0]  pc_cur,
   input  logic [XLEN-1:0]  pc_inc,
   input  logic [OFF_W-1:0] off,
   input  logic [TGT_W-1:0] tgt,
   output logic [XLEN-1:0]  br_addr,
   output logic [XLEN-1:0]  jmp_addr
);
   localparam int EXT_W = XLEN - OFF_W - 2;
   localparam int RGN_W = XLEN - TGT_W - 2;

   generate
      if (EXT_W < 1) begin : g_bad_off
         $error("npc_target: offset too wide for XLEN");
      end
      if (RGN_W < 1) begin : g_bad_tgt
         $error("npc_target: jump target too wide for XLEN");
      end
   endgenerate

   logic [XLEN-1:0] disp;
   assign disp    = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
   assign br_addr = pc_inc + disp;

   logic [RGN_W-1:0] region;
   generate
      if (REGION_FROM_INC) begin : g_rgn_inc
         assign region = pc_inc[XLEN-1 -: RGN_W];
      end else begin : g_rgn_cur
         assign region = pc_cur[XLEN-1 -: RGN_W];
      end
   endgenerate

   assign jmp_addr = {region, tgt, 2'b00};
endmodule

// File: rtl/npc_link.sv
module npc_link
   import npc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int IDX_W    = 5,
   parameter int LINK_REG = 31
) (
   input  npc_op_e          op,
   input  logic [IDX_W-1:0] rd,
   input  logic [XLEN-1:0]  pc_inc,
   input  logic             cancel,
   output logic             we,
   output logic [IDX_W-1:0] idx,
   output logic [XLEN-1:0]  data
);
   generate
      if (LINK_REG < 1 || LINK_REG >= (1 << IDX_W)) begin : g_bad_link
         $error("npc_link: LINK_REG out of range");
      end
   endgenerate

   logic wants;
   always_comb begin
      wants = 1'b0;
      idx   = '0;
      if (op == OP_JAL) begin
         wants = 1'b1;
         idx   = IDX_W'(LINK_REG);
      end else if (op == OP_JALR) begin
         wants = 1'b1;
         idx   = rd;
      end
   end

   assign we   = wants && !cancel && (idx != '0);
   assign data = pc_inc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int              XLEN            = 32,
   parameter int              OFF_W           = 16,
   parameter int              TGT_W           = 26,
   parameter int              IDX_W           = 5,
   parameter int              LINK_REG        = 31,
   parameter bit              REGION_FROM_INC = 1'b1,
   parameter logic [XLEN-1:0] RESET_PC        = 32'hBFC0_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [3:0]       op,
   input  logic [OFF_W-1:0] br_off,
   input  logic [TGT_W-1:0] jmp_tgt,
   input  logic [XLEN-1:0]  rs_val,
   input  logic [XLEN-1:0]  rt_val,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             exc_req,
   input  logic [XLEN-1:0]  exc_pc,
   output logic [XLEN-1:0]  pc,
   output logic             link_we,
   output logic [IDX_W-1:0] link_idx,
   output logic [XLEN-1:0]  link_data
);
   localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

   npc_op_e         op_e;
   logic [XLEN-1:0] pc_inc, br_addr, jmp_addr, nxt;
   logic            taken;

   assign op_e   = npc_op_e'(op);
   assign pc_inc = pc + INSN_BYTES;

   npc_cond #(.XLEN(XLEN)) u_cond (
      .op(op_e), .a(rs_val), .b(rt_val), .taken(taken)
   );

   npc_target #(
      .XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W),
      .REGION_FROM_INC(REGION_FROM_INC)
   ) u_tgt (
      .pc_cur(pc), .pc_inc(pc_inc), .off(br_off), .tgt(jmp_tgt),
      .br_addr(br_addr), .jmp_addr(jmp_addr)
   );

   npc_link #(.XLEN(XLEN), .IDX_W(IDX_W), .LINK_REG(LINK_REG)) u_link (
      .op(op_e), .rd(rd_idx), .pc_inc(pc_inc), .cancel(exc_req),
      .we(link_we), .idx(link_idx), .data(link_data)
   );

   always_comb begin
      if (exc_req) begin
         nxt = exc_pc;
      end else begin
         unique case (op_e)
            OP_J, OP_JAL:   nxt = jmp_addr;
            OP_JR, OP_JALR: nxt = rs_val;
            default:        nxt = (is_branch(op_e) && taken) ? br_addr : pc_inc;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= RESET_PC;
      else if (step) pc <= nxt;
   end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int XLEN     = 32,
   parameter int TGT_W    = 26,
   parameter int IDX_W    = 5,
   parameter int LINK_REG = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step,
   input logic [3:0]       op,
   input logic [XLEN-1:0]  rs_val,
   input logic             exc_req,
   input logic [XLEN-1:0]  exc_pc,
   input logic [XLEN-1:0]  pc,
   input logic             link_we,
   input logic [IDX_W-1:0] link_idx,
   input logic [XLEN-1:0]  link_data
);
   localparam int RGN_W = XLEN - TGT_W - 2;
   logic [XLEN-1:0] inc_c;
   assign inc_c = pc + XLEN'(4);

   a_r1_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      step && !exc_req && op == 4'd0 |=> pc == $past(inc_c));
   a_r5_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
      step && !exc_req && (op == 4'd7 || op == 4'd8)
      |=> pc[XLEN-1 -: RGN_W] == $past(inc_c[XLEN-1 -: RGN_W]) && pc[1:0] == 2'b00);
   a_r6_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
      step && !exc_req && (op == 4'd9 || op == 4'd10) |=> pc == $past(rs_val));
   a_r7_jal_link: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req && op == 4'd8
      |-> link_we && link_idx == IDX_W'(LINK_REG) && link_data == inc_c);
   a_r8_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> link_idx != '0);
   a_r9_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      step && exc_req |=> pc == $past(exc_pc));
   a_r9_no_link: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> !link_we);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(pc));
endmodule

bind npc_unit npc_unit_chk #(
   .XLEN(XLEN), .TGT_W(TGT_W), .IDX_W(IDX_W), .LINK_REG(LINK_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step(step), .op(op), .rs_val(rs_val),
   .exc_req(exc_req), .exc_pc(exc_pc), .pc(pc), .link_we(link_we),
   .link_idx(link_idx), .link_data(link_data)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic [3:0]  op = '0;
   logic [15:0] br_off = '0;
   logic [25:0] jmp_tgt = '0;
   logic [31:0] rs_val = '0, rt_val = '0, exc_pc = '0;
   logic [4:0]  rd_idx = '0;
   logic        exc_req = 1'b0;
   logic [31:0] pc, link_data;
   logic        link_we;
   logic [4:0]  link_idx;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   npc_unit u0 (
      .clk(clk), .rst_n(rst_n), .step(step), .op(op), .br_off(br_off),
      .jmp_tgt(jmp_tgt), .rs_val(rs_val), .rt_val(rt_val), .rd_idx(rd_idx),
      .exc_req(exc_req), .exc_pc(exc_pc), .pc(pc), .link_we(link_we),
      .link_idx(link_idx), .link_data(link_data)
   );

   localparam int N = 19;
   localparam logic [31:0] V_PC [N] = '{
      32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'h0000_2000,
      32'h0000_2000, 32'h0000_2000, 32'h0000_2000, 32'h0000_2000, 32'h0000_2000,
      32'h8000_0180, 32'h1FFF_FFFC, 32'h0000_1000, 32'h0000_3000, 32'h0000_3000,
      32'h0000_3000, 32'h0000_1000, 32'h0000_1000, 32'h0000_2000};
   localparam logic [3:0] V_OP [N] = '{
      4'd0, 4'd1, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd6, 4'd4,
      4'd7, 4'd7, 4'd8, 4'd9, 4'd10, 4'd10, 4'd1, 4'd12, 4'd3};
   localparam logic [15:0] V_OFF [N] = '{
      16'h0000, 16'h0004, 16'h0004, 16'hFFFE, 16'h0001, 16'h0001, 16'h0001,
      16'h0001, 16'h0001, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
      16'h0000, 16'h0000, 16'h8000, 16'h0004, 16'h0001};
   localparam logic [25:0] V_TGT [N] = '{
      26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0,
      26'h0040002, 26'h0000010, 26'h0000100, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0};
   localparam logic [31:0] V_RS [N] = '{
      32'h0, 32'h5, 32'h5, 32'h5, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 32'h1,
      32'h8000_0000, 32'h0, 32'h0, 32'h0, 32'h0000_ABC0, 32'h0000_4000,
      32'h0000_5000, 32'h9, 32'h0, 32'hFFFF_FFFF};
   localparam logic [31:0] V_RT [N] = '{
      32'h0, 32'h5, 32'h6, 32'h6, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
      32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h9, 32'h0, 32'h0};
   localparam logic [4:0] V_RD [N] = '{
      5'd3, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0,
      5'd0, 5'd0, 5'd4, 5'd9, 5'd7, 5'd0, 5'd0, 5'd0, 5'd0};
   localparam logic [31:0] V_EXP [N] = '{
      32'h0000_1004, 32'h0000_1014, 32'h0000_1004, 32'h0000_0FFC, 32'h0000_2008,
      32'h0000_2004, 32'h0000_2008, 32'h0000_2008, 32'h0000_2004, 32'h0000_2004,
      32'h8010_0008, 32'h2000_0040, 32'h0000_0400, 32'h0000_ABC0, 32'h0000_4000,
      32'h0000_5000, 32'hFFFE_1004, 32'h0000_1004, 32'h0000_2004};
   localparam bit V_WE [N] = '{
      0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0};

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic place_pc(logic [31:0] v);
      exc_req = 1'b1; exc_pc = v; step = 1'b1; op = 4'd7;
      @(posedge clk); @(negedge clk);
      exc_req = 1'b0;
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R11 reset pc", pc, 32'hBFC0_0000);
      chk("R7 no link at reset", {31'd0, link_we}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 hold after reset", pc, 32'hBFC0_0000);

      for (int i = 0; i < N; i++) begin
         place_pc(V_PC[i]);
         op = V_OP[i]; br_off = V_OFF[i]; jmp_tgt = V_TGT[i];
         rs_val = V_RS[i]; rt_val = V_RT[i]; rd_idx = V_RD[i]; step = 1'b1;
         #1;
         chk("R7 R8 link request", {31'd0, link_we}, {31'd0, V_WE[i]});
         if (V_WE[i]) begin
            chk("R7 link data", link_data, V_PC[i] + 32'd4);
            chk("R7 link index", {27'd0, link_idx},
                {27'd0, (V_OP[i] == 4'd8) ? 5'd31 : V_RD[i]});
         end
         @(posedge clk); @(negedge clk);
         chk($sformatf("R1 R2 R3 R4 R5 R6 vector %0d next pc", i), pc, V_EXP[i]);
      end

      // R9: redirect wins over a jump and link, and cancels its write
      place_pc(32'h0000_1000);
      op = 4'd8; jmp_tgt = 26'h0000100; exc_req = 1'b1; exc_pc = 32'h8000_0180;
      #1;
      chk("R9 link cancelled", {31'd0, link_we}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R9 redirect target", pc, 32'h8000_0180);
      exc_req = 1'b0;

      // R10: step low holds the PC even with a jump presented
      step = 1'b0; op = 4'd9; rs_val = 32'h1234_5678;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R10 hold", pc, 32'h8000_0180);

      // R11: asynchronous reset returns to the reset address
      rst_n = 1'b0; #1;
      chk("R11 reset again", pc, 32'hBFC0_0000);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule